// File: doc/BRIEF.md
# Sequential Ones-Counting Engine

This block reports how many bits of an 8-bit operand are set. It does not use an adder tree. It uses a small control state machine and a separate datapath. The operand is captured while the engine is idle. After a start request, the captured value moves right by one position on each clock, and a counter adds the bit that leaves at the bottom. The engine stops as soon as no set bits remain, so a sparse operand with low set bits finishes early.

The start request can come from a source with no timing relation to the clock. It passes through a two-stage synchronizer before the controller acts on it. Start and done form a four-phase handshake:

1. The requester raises start.
2. The engine raises done when it has finished.
3. The result stays valid and frozen until start drops.
4. The engine then returns to idle and clears its count.

All register updates chosen in a state take effect on the next rising clock edge.

Top module: `popcnt_seq`

## Requirements
- R1: With `rst` high at a rising edge, that edge sets `done` low and `ones_count` to 0 and returns the engine to idle. The reset is synchronous.
- R2: `start_async` passes through two synchronizer flops. If it is raised before rising edge 1, the engine enters its counting state on edge 3.
- R3: When `done` is high, `ones_count` holds the number of bits equal to one in the captured operand, as an unsigned value from 0 to 8.
- R4: Counting moves the operand right by one per clock and stops when the remaining value is zero. For an operand whose highest set bit is at index k, `done` is first high after edge 5+k, counted from the raise of start. For an operand of zero, `done` is first high after edge 4.
- R5: The operand is captured only in idle while the synchronized start is low. Changes on `operand_in` after start has been seen do not change the result.
- R6: While `done` is high and `start_async` stays high, `done` remains high and `ones_count` does not change, whatever `operand_in` does.
- R7: After `start_async` falls, `done` is still high after edge 2 and low after edge 3. `ones_count` reads 0 after edge 4.
- R8: `ones_count` rises by at most one per clock and never exceeds 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_async | input | 1 | Start request, may be asynchronous to clk; held high until the result is taken |
| operand_in | input | 8 | Value whose set bits are counted |
| ones_count | output | 4 | Number of set bits, valid while done is high |
| done | output | 1 | High when the count is complete; held until start falls |

## Verification
The bench covers these cases and what a broken design would show:

- **Zero operand.** An engine that always makes eight passes, or that never exits early, would show a latency far beyond four edges.
- **All ones.** This catches a count register one bit too narrow, which would wrap to 0, and a loop that stops one pass short.
- **Operand changed mid-run and while done is held.** These expose a design that keeps loading the operand outside idle.
- **Start released and reset mid-run.** Edge-exact latency checks on these catch a missing or extra synchronizer stage and a done that clears too early or too late.

// File: rtl/popcnt_pkg.sv
package popcnt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_DONE  = 2'd2
  } popcnt_state_e;

endpackage

// File: rtl/popcnt_sync.sv
module popcnt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b0;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/popcnt_dpath.sv
module popcnt_dpath #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic              step_en,
  input  logic [DATA_W-1:0] operand_in,
  output logic              rem_zero,
  output logic [CNT_W-1:0]  ones_count
);
  logic [DATA_W-1:0] work_q;
  logic [CNT_W-1:0]  tally_q;
  logic [CNT_W-1:0]  lsb_ext;

  assign lsb_ext = {{(CNT_W-1){1'b0}}, work_q[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      work_q  <= '0;
      tally_q <= '0;
    end else if (load_en) begin
      work_q  <= operand_in;
      tally_q <= '0;
    end else if (step_en) begin
      work_q  <= work_q >> 1;
      tally_q <= tally_q + lsb_ext;
    end
  end

  assign rem_zero   = (work_q == '0);
  assign ones_count = tally_q;
endmodule

// File: rtl/popcnt_ctrl.sv
module popcnt_ctrl
  import popcnt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_s,
  input  logic rem_zero,
  output logic load_en,
  output logic step_en,
  output logic busy,
  output logic done
);
  popcnt_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_s)  state_d = ST_COUNT;
      ST_COUNT: if (rem_zero) state_d = ST_DONE;
      ST_DONE:  if (!start_s) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign load_en = (state_q == ST_IDLE) && !start_s;
  assign step_en = (state_q == ST_COUNT) && !rem_zero;
  assign busy    = (state_q == ST_COUNT);
  assign done    = (state_q == ST_DONE);
endmodule

// File: rtl/popcnt_seq.sv
module popcnt_seq #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_async,
  input  logic [DATA_W-1:0] operand_in,
  output logic [CNT_W-1:0]  ones_count,
  output logic              done
);
  logic start_s;
  logic load_en;
  logic step_en;
  logic rem_zero;
  logic busy;

  popcnt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (start_async),
    .dout (start_s)
  );

  popcnt_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start_s  (start_s),
    .rem_zero (rem_zero),
    .load_en  (load_en),
    .step_en  (step_en),
    .busy     (busy),
    .done     (done)
  );

  popcnt_dpath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .load_en    (load_en),
    .step_en    (step_en),
    .operand_in (operand_in),
    .rem_zero   (rem_zero),
    .ones_count (ones_count)
  );
endmodule

// File: rtl/popcnt_seq_chk.sv
module popcnt_seq_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start_s,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] ones_count
);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(DATA_W);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!done && ones_count == '0)); // R1

  AST_ENTER_ON_START: assert property (@(posedge clk) disable iff (rst)
    (!busy && !done && start_s) |=> busy); // R2

  AST_DONE_FROM_COUNT: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy)); // R4

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (done && start_s) |=> (done && $stable(ones_count))); // R6

  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (done && !start_s) |=> !done); // R7

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (ones_count != $past(ones_count)) |-> (ones_count == $past(ones_count) + ONE_C || ones_count == '0)); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    ones_count <= MAX_C); // R8
endmodule

bind popcnt_seq popcnt_seq_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_s    (start_s),
  .busy       (busy),
  .done       (done),
  .ones_count (ones_count)
);

// File: tb/tb_popcnt_seq.sv
`timescale 1ns/1ps
module tb_popcnt_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_async = 1'b0;
  logic [7:0] operand_in = 8'h00;
  logic [3:0] ones_count;
  logic       done;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  popcnt_seq dut (
    .clk         (clk),
    .rst         (rst),
    .start_async (start_async),
    .operand_in  (operand_in),
    .ones_count  (ones_count),
    .done        (done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int exp_lat(input logic [7:0] v);
    int hi = -1;
    for (int i = 0; i < 8; i++) if (v[i]) hi = i;
    return (hi < 0) ? 4 : 5 + hi;
  endfunction

  // Release start and check the done fall and the count clear timing (R7)
  task automatic release_start;
    start_async = 1'b0;
    tick();
    tick();
    check(done == 1'b1, "R7 done after edge 2", int'(done), 1);
    tick();
    check(done == 1'b0, "R7 done after edge 3", int'(done), 0);
    tick();
    check(ones_count == 4'd0, "R7 count cleared in idle", int'(ones_count), 0);
  endtask

  // Run one operand; change_to is driven on operand_in after the start is seen
  task automatic run_op(input logic [7:0] v, input bit do_change, input logic [7:0] change_to,
                        input string req);
    int lat = 0;
    operand_in  = v;
    start_async = 1'b1;
    while (!done && lat < 40) begin
      tick();
      lat++;
      if (lat == 2) check(done == 1'b0, "R2 no done during sync", int'(done), 0);
      if (do_change && lat == 3) operand_in = change_to;
    end
    check(lat == exp_lat(v), "R4 latency", lat, exp_lat(v));
    check(ones_count == 4'($countones(v)), req, int'(ones_count), $countones(v));
  endtask

  task automatic t_reset;
    rst = 1'b1;
    tick();
    tick();
    check(done == 1'b0, "R1 done low in reset", int'(done), 0);
    check(ones_count == 4'd0, "R1 count zero in reset", int'(ones_count), 0);
    rst = 1'b0;
    tick();
  endtask

  task automatic t_patterns;
    run_op(8'h00, 1'b0, 8'h00, "R3 zero operand");   release_start();
    run_op(8'hFF, 1'b0, 8'h00, "R3 all ones");       release_start();
    run_op(8'h01, 1'b0, 8'h00, "R3 only lsb");       release_start();
    run_op(8'h80, 1'b0, 8'h00, "R3 only msb");       release_start();
    run_op(8'hA5, 1'b0, 8'h00, "R3 mixed a5");       release_start();
    run_op(8'h1C, 1'b0, 8'h00, "R3 mixed 1c");       release_start();
  endtask

  task automatic t_change_mid;
    run_op(8'h03, 1'b1, 8'hFF, "R5 operand change ignored");
    release_start();
  endtask

  task automatic t_hold;
    run_op(8'h6B, 1'b0, 8'h00, "R3 before hold");
    for (int i = 0; i < 6; i++) begin
      operand_in = 8'(i * 37);
      tick();
    end
    check(done == 1'b1, "R6 done held", int'(done), 1);
    check(ones_count == 4'd5, "R6 count held", int'(ones_count), 5);
    release_start();
  endtask

  task automatic t_reset_mid;
    operand_in  = 8'hF0;
    start_async = 1'b1;
    for (int i = 0; i < 5; i++) tick();
    rst = 1'b1;
    tick();
    check(done == 1'b0, "R1 done after mid reset", int'(done), 0);
    check(ones_count == 4'd0, "R1 count after mid reset", int'(ones_count), 0);
    rst = 1'b0;
    start_async = 1'b0;
    for (int i = 0; i < 4; i++) tick();
    check(done == 1'b0, "R1 stays idle", int'(done), 0);
    run_op(8'hF0, 1'b0, 8'h00, "R8 count after reset recovery");
    release_start();
  endtask

  bit finished = 1'b0;

  initial begin
    @(negedge clk);
    t_reset();
    t_patterns();
    t_change_mid();
    t_hold();
    t_reset_mid();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule